// File: doc/BRIEF.md
# Deficit Idle Count Lane Aligner

This block does the gap and alignment bookkeeping of a 64-bit transmit path. The path moves eight bytes per clock, and a frame may only begin in byte lane 0 or lane 4. For each frame it is told about, the block reports three things. The first is the lane that frame starts in. The second is how many idle bytes follow the frame. The third is the updated deficit count.

A plain aligner rounds every gap up to the next four-byte boundary, so every frame loses a little throughput. When deficit idle counting is enabled, this block may instead shorten a gap by up to three bytes. It remembers the shortfall in a 0..3 counter and pays it back later, so the average gap equals the configured value. With counting disabled, gaps are only ever stretched.

The surrounding MAC pulses a valid strobe once per frame and presents the payload length and the configured gap with it. The result appears one clock later. Frame data, preamble, FCS insertion and line coding are handled elsewhere.

Top module: `dic_lane_aligner`

## Requirements
- R1: Every reported start lane is a multiple of LANES/2, so with the default 8 lanes it is 0 or 4.
- R2: The raw next lane after a frame is (start lane + payload length + 4 + gap) modulo 8. Only the low three bits of the length and of the gap affect it.
- R3: With deficit counting on, the offset is the raw lane modulo 4. The offset gains 4 when the deficit plus the offset is 4 or more. The next start lane is (raw lane − offset) modulo 8, and the new deficit is (deficit + offset) modulo 4.
- R4: With deficit counting off, a nonzero raw-lane remainder (modulo 4) is always pushed to the next aligned lane. The gap only grows, and the deficit count does not change.
- R5: When the configured gap is 0, the frame starts on lane 0 whatever came before it. The reported idle count is then the number of bytes needed to fill out the last 8-byte word.
- R6: For a nonzero gap, the reported idle count is gap − offset when the offset is below 4, and gap + 8 − offset otherwise. Supported nonzero gaps are 3 to 255.
- R7: A valid strobe yields exactly one single-cycle out_vld on the next clock. Cycles without a strobe leave the lane and deficit state unchanged.
- R8: A synchronous reset clears the lane and deficit state and drops out_vld. The first frame after reset starts on lane 0.
- R9: out_deficit reports the deficit count after the frame, in the range 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | One pulse per frame |
| in_len | input | LEN_W | Payload length in bytes, excluding FCS |
| cfg_gap | input | GAP_W | Configured inter-frame gap in bytes |
| dic_en | input | 1 | Deficit idle counting enable (static) |
| out_vld | output | 1 | Result valid, one cycle |
| out_lane | output | $clog2(LANES) | Start lane of the frame |
| out_idle | output | GAP_W+1 | Idle bytes inserted after the frame |
| out_deficit | output | $clog2(LANES)-1 | Deficit count after the frame |

## Verification
The bench sweeps payload lengths 60 to 91, ten back-to-back frames at each length, with counting both on and off. Together these reach every raw-lane remainder from every deficit value. A wrong carry threshold in the deficit test would let the deficit exceed three bytes, and would show up as a misplaced start lane and an idle count off by four.

A zero gap is mixed into runs that have a nonzero history. This catches a design that keeps its stored lane when the gap is zero instead of restarting on lane 0.

Idle cycles between frames check that the state does not drift without a strobe. Lengths near 65535 check that the modulo arithmetic uses only the low bits of the length. A mid-run reset checks that the next frame starts on lane 0.

// File: rtl/dicla_pkg.sv
package dicla_pkg;
   // bytes of frame check sequence appended after the payload
   localparam int unsigned FCS_BYTES = 4;
   // smallest nonzero gap for which a shortened gap stays non-negative
   localparam int unsigned MIN_NONZERO_GAP = 3;
endpackage

// File: rtl/dicla_offset.sv
// Raw lane, alignment offset and deficit update for one frame.
module dicla_offset #(
   parameter int unsigned LANES = 8,
   localparam int unsigned LANE_W = $clog2(LANES),
   localparam int unsigned DEF_W = LANE_W - 1,
   localparam int unsigned ALIGN = LANES / 2
) (
   input  logic [LANE_W-1:0] start_lane,
   input  logic [LANE_W-1:0] len_lo,
   input  logic [LANE_W-1:0] gap_lo,
   input  logic [DEF_W-1:0]  deficit,
   input  logic              dic_en,
   output logic [LANE_W-1:0] end_lane,
   output logic [LANE_W-1:0] offset,
   output logic [LANE_W-1:0] next_lane,
   output logic [DEF_W-1:0]  next_deficit
);
   import dicla_pkg::*;

   logic [LANE_W-1:0] raw_lane;
   logic [DEF_W-1:0]  rem;
   logic [DEF_W:0]    def_sum;
   logic              wrap;

   always_comb begin
      end_lane = start_lane + len_lo + LANE_W'(FCS_BYTES % LANES);
      raw_lane = end_lane + gap_lo;
      rem      = raw_lane[DEF_W-1:0];
      def_sum  = {1'b0, deficit} + {1'b0, rem};
      if (dic_en) begin
         wrap = (def_sum >= (DEF_W+1)'(ALIGN));
      end else begin
         wrap = (rem != '0);
      end
      // ALIGN is a power of two, so adding it sets the top lane bit
      offset       = {wrap, rem};
      next_lane    = raw_lane - offset;
      next_deficit = dic_en ? def_sum[DEF_W-1:0] : deficit;
   end
endmodule

// File: rtl/dicla_idle.sv
// Idle byte count following a frame.
module dicla_idle #(
   parameter int unsigned LANES = 8,
   parameter int unsigned GAP_W = 8,
   localparam int unsigned LANE_W = $clog2(LANES),
   localparam int unsigned IDLE_W = GAP_W + 1
) (
   input  logic [GAP_W-1:0]  gap,
   input  logic [LANE_W-1:0] end_lane,
   input  logic [LANE_W-1:0] offset,
   output logic [IDLE_W-1:0] idle
);
   logic [LANE_W-1:0] fill;

   always_comb begin
      fill = '0 - end_lane;
      if (gap == '0) begin
         idle = IDLE_W'(fill);
      end else if (offset[LANE_W-1]) begin
         idle = IDLE_W'(gap) + IDLE_W'(LANES) - IDLE_W'(offset);
      end else begin
         idle = IDLE_W'(gap) - IDLE_W'(offset);
      end
   end
endmodule

// File: rtl/dic_lane_aligner.sv
module dic_lane_aligner #(
   parameter int unsigned LANES = 8,
   parameter int unsigned LEN_W = 16,
   parameter int unsigned GAP_W = 8,
   localparam int unsigned LANE_W = $clog2(LANES),
   localparam int unsigned DEF_W = LANE_W - 1,
   localparam int unsigned ALIGN = LANES / 2,
   localparam int unsigned IDLE_W = GAP_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [LEN_W-1:0]  in_len,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              dic_en,
   output logic              out_vld,
   output logic [LANE_W-1:0] out_lane,
   output logic [IDLE_W-1:0] out_idle,
   output logic [DEF_W-1:0]  out_deficit
);
   generate
      if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two of at least 4");
      end
      if (LEN_W < LANE_W || GAP_W < LANE_W) begin : g_bad_widths
         $error("LEN_W and GAP_W must cover the lane index");
      end
   endgenerate

   logic [LANE_W-1:0] lane_q;
   logic [DEF_W-1:0]  def_q;
   logic [LANE_W-1:0] start_eff;
   logic [LANE_W-1:0] end_lane;
   logic [LANE_W-1:0] offset;
   logic [LANE_W-1:0] next_lane;
   logic [DEF_W-1:0]  next_def;
   logic [IDLE_W-1:0] idle;

   assign start_eff = (cfg_gap == '0) ? '0 : lane_q;

   dicla_offset #(.LANES(LANES)) u_offset (
      .start_lane  (start_eff),
      .len_lo      (in_len[LANE_W-1:0]),
      .gap_lo      (cfg_gap[LANE_W-1:0]),
      .deficit     (def_q),
      .dic_en      (dic_en),
      .end_lane    (end_lane),
      .offset      (offset),
      .next_lane   (next_lane),
      .next_deficit(next_def)
   );

   dicla_idle #(.LANES(LANES), .GAP_W(GAP_W)) u_idle (
      .gap     (cfg_gap),
      .end_lane(end_lane),
      .offset  (offset),
      .idle    (idle)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         lane_q      <= '0;
         def_q       <= '0;
         out_vld     <= 1'b0;
         out_lane    <= '0;
         out_idle    <= '0;
         out_deficit <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            lane_q      <= next_lane;
            def_q       <= next_def;
            out_lane    <= start_eff;
            out_idle    <= idle;
            out_deficit <= next_def;
         end
      end
   end

   p_start_aligned_r1: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (int'(out_lane) % ALIGN) == 0);

   p_gap_zero_lane0_r5: assert property (@(posedge clk) disable iff (rst)
      (in_vld && cfg_gap == '0) |=> out_lane == '0);

   p_nodic_stretch_r4: assert property (@(posedge clk) disable iff (rst)
      (in_vld && !dic_en && cfg_gap != '0) |=>
         (int'(out_idle) >= int'($past(cfg_gap))) && (int'(out_idle) < int'($past(cfg_gap)) + ALIGN));

   p_dic_bound_r3: assert property (@(posedge clk) disable iff (rst)
      (in_vld && dic_en && int'(cfg_gap) >= ALIGN - 1) |=>
         (int'(out_idle) + ALIGN > int'($past(cfg_gap))) && (int'(out_idle) < int'($past(cfg_gap)) + ALIGN));

   p_one_result_r7: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld && $stable(out_lane) && $stable(out_deficit));

   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> !out_vld && out_deficit == '0 && out_lane == '0);
endmodule

// File: tb/sim_dic_lane_aligner.sv
`timescale 1ns / 1ps
module sim_dic_lane_aligner;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [15:0] in_len = '0;
   logic [7:0]  cfg_gap = 8'd12;
   logic        dic_en = 1'b1;
   logic        out_vld;
   logic [2:0]  out_lane;
   logic [8:0]  out_idle;
   logic [1:0]  out_deficit;

   int checks = 0;
   int errors = 0;
   int m_lane = 0;
   int m_def = 0;

   always #5 clk = ~clk;

   dic_lane_aligner u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_len(in_len),
      .cfg_gap(cfg_gap), .dic_en(dic_en), .out_vld(out_vld),
      .out_lane(out_lane), .out_idle(out_idle), .out_deficit(out_deficit)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // call at a falling edge; returns at the next falling edge with results checked
   task automatic send(input int len, input int gap, input bit dic, input string req);
      int start, raw, off, nl, nd, idle, endl;
      in_len  = 16'(len);
      cfg_gap = 8'(gap);
      dic_en  = dic;
      in_vld  = 1'b1;
      start = (gap == 0) ? 0 : m_lane;
      endl  = (start + len + 4) % 8;
      raw   = (start + len + 4 + gap) % 8;
      off   = raw % 4;
      if (dic) begin
         if (m_def + off >= 4) off += 4;
         nd = (m_def + off) % 4;
      end else begin
         if (off > 0) off += 4;
         nd = m_def;
      end
      nl = (raw - off + 8) % 8;
      if (gap == 0) idle = (8 - endl) % 8;
      else if (off >= 4) idle = gap + 8 - off;
      else idle = gap - off;
      @(negedge clk);
      chk(out_vld == 1'b1, {req, " R7 valid"}, int'(out_vld), 1);
      chk(int'(out_lane) == start, {req, " lane"}, int'(out_lane), start);
      chk(int'(out_idle) == idle, {req, " R6 idle"}, int'(out_idle), idle);
      chk(int'(out_deficit) == nd, {req, " R9 deficit"}, int'(out_deficit), nd);
      m_lane = nl;
      m_def  = nd;
   endtask

   task automatic quiet(input int n);
      in_vld = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(out_vld == 1'b0, "R7 no strobe", int'(out_vld), 0);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      in_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_lane = 0;
      m_def = 0;
   endtask

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      void'($urandom(32'd20251));
      do_reset();
      chk(out_vld == 1'b0, "R8 reset valid", int'(out_vld), 0);
      chk(out_deficit == 2'd0, "R8 reset deficit", int'(out_deficit), 0);
      // R8: first frame after reset on lane 0
      send(61, 12, 1'b1, "R8 first");
      quiet(1);

      // R2 R3 R4: length sweep, ten back-to-back frames, both modes
      for (int d = 0; d < 2; d++) begin
         do_reset();
         for (int len = 60; len < 92; len++) begin
            for (int k = 0; k < 10; k++) send(len, 12, d == 0, d == 0 ? "R3 sweep" : "R4 sweep");
            quiet(2);
         end
      end

      // R5: zero gap after nonzero history
      do_reset();
      send(63, 12, 1'b1, "R5 prime");
      send(65, 0, 1'b1, "R5 gap0");
      send(70, 0, 1'b0, "R5 gap0 nodic");
      quiet(1);

      // R7: state holds through idle cycles
      send(61, 13, 1'b1, "R7 before");
      quiet(5);
      send(62, 13, 1'b1, "R7 after");

      // R2: only low bits of length count
      send(65535, 12, 1'b1, "R2 maxlen");
      send(65533, 255, 1'b1, "R2 maxgap");
      send(60, 3, 1'b1, "R6 min gap");
      quiet(1);

      // R8: reset mid run
      send(61, 12, 1'b1, "R8 prime");
      do_reset();
      send(60, 12, 1'b1, "R8 after reset");

      // R1 R3 R4 R5: constrained random
      for (int i = 0; i < 3000; i++) begin
         int len, gap;
         bit dic;
         len = ($urandom % 8 == 0) ? 60 + $urandom % 65476 : 60 + $urandom % 1500;
         gap = ($urandom % 8 == 0) ? 0 : 3 + $urandom % 253;
         dic = ($urandom % 4 != 0);
         if (i % 500 == 0) do_reset();
         send(len, gap, dic, "R1 random");
         if ($urandom % 16 == 0) quiet(1 + $urandom % 3);
      end
      quiet(1);
      summary();
   end
endmodule